// File: doc/BRIEF.md
# Speculative Line-State Tracker for a Primary Data Cache

This block keeps the speculation bookkeeping for every line of one core's primary data cache in a multi-core machine that runs threads speculatively. Each line has a valid flag, a tag and three marks:

- **read**: a speculative load touched the line.
- **modified**: a speculative store touched it.
- **pre-invalidate**: a later thread wrote it.

The core presents loads and stores on an access port. The refill path installs lines on a fill port. Every write seen on the shared write-through bus arrives on a snoop port, along with the number of the core that issued it.

A sequencing input supplies one sequence number per core. Sequence 0 is the non-speculative head thread, and larger numbers are more speculative. A bus write from an earlier thread invalidates the matching local line at once. If that line had been speculatively read, the block raises a one-cycle violation pulse. A bus write from a later thread leaves the line usable and only sets its pre-invalidate mark. Two flash operations act on all lines in a single cycle:

- **Commit** invalidates every pre-invalidated line.
- **Squash** invalidates every speculatively modified line.

Both operations clear all marks.

A two-state machine governs the violation output. In ARMED, a violating snoop produces a pulse and moves the machine to TRIPPED (transition "violate"). In TRIPPED, further violations are still applied to the lines but give no pulse. Commit or squash returns the machine to ARMED (transition "rearm"). Reset enters ARMED.

Top module: `spec_line_tracker`

## Requirements
- R1: After reset every line is invalid, `viol_o` and `acc_hit_o` are 0, and a lookup of any set with tag 0 misses.
- R2: A fill writes the tag into the chosen set and way and marks the line valid. An access to that set with that tag drives `acc_hit_o` to 1 in the cycle after the access. A different tag gives 0.
- R3: When the local sequence number is non-zero, a load that hits sets the line's read mark. A later snoop from a foreign core with a lower sequence number that hits the line raises `viol_o` for exactly the cycle after the snoop.
- R4: A snoop from a foreign core with a lower sequence number invalidates a hitting line, whether or not the line was read. The next access misses.
- R5: A snoop from a core with a higher sequence number keeps the line valid, gives no violation, and sets its pre-invalidate mark. Commit (`commit_i`=1) invalidates exactly the pre-invalidated lines.
- R6: Squash (`squash_i`=1) invalidates exactly the lines that a speculative store hit. All other lines stay valid.
- R7: When the local sequence number is 0, loads and stores set no marks. A later squash keeps such stored lines, and a later earlier-thread snoop gives no violation.
- R8: Snoops whose core number equals `LOCAL_ID` change nothing and never violate.
- R9: After one violation pulse, further violating snoops give no pulse until a commit or squash. After that, a violation pulses again.
- R10: Commit and squash clear every read, modified and pre-invalidate mark.
- R11: In a cycle with commit or squash, the access, snoop and fill inputs are ignored. `acc_hit_o` and `viol_o` are 0 in the next cycle, and no line changes except through the flash operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| seq_vec_i | input | NCORE*SEQ_W | Sequence number of core c in bits [c*SEQ_W +: SEQ_W]; 0 = head |
| fill_vld_i | input | 1 | Install a line |
| fill_set_i | input | log2(SETS) | Fill set |
| fill_way_i | input | log2(WAYS) | Fill way |
| fill_tag_i | input | TAG_W | Fill tag |
| acc_vld_i | input | 1 | Local access valid |
| acc_wr_i | input | 1 | 1 = store, 0 = load |
| acc_set_i | input | log2(SETS) | Access set |
| acc_tag_i | input | TAG_W | Access tag |
| snp_vld_i | input | 1 | Bus write observed |
| snp_core_i | input | log2(NCORE) | Core that issued the bus write |
| snp_set_i | input | log2(SETS) | Snooped set |
| snp_tag_i | input | TAG_W | Snooped tag |
| commit_i | input | 1 | Local thread completed |
| squash_i | input | 1 | Local thread restarts |
| acc_hit_o | output | 1 | Registered hit result of the previous cycle's access |
| viol_o | output | 1 | Registered dependence-violation pulse |

## Verification
A wrong mark shows up at the ports at the next operation that consults it:

- A read mark that is stuck or lost changes `viol_o` one cycle after an earlier-thread snoop to that line.
- A lost or spurious pre-invalidate or modified mark changes the hit result of the first lookup after the next commit or squash.
- A wrong valid flag or tag changes `acc_hit_o` on the very next access.
- An error in the state machine shows as a missing or doubled pulse on the second violating snoop of a thread.

// File: rtl/spec_trk_pkg.sv
package spec_trk_pkg;

    typedef enum logic [0:0] {
        TRK_ARMED   = 1'b0,
        TRK_TRIPPED = 1'b1
    } trk_state_e;

    typedef struct packed {
        logic rd;
        logic md;
        logic pi;
    } spec_bits_t;

endpackage

// File: rtl/spec_order_cmp.sv
module spec_order_cmp #(
    parameter int NCORE    = 4,
    parameter int SEQ_W    = 2,
    parameter int LOCAL_ID = 1
) (
    input  logic [NCORE*SEQ_W-1:0]   seq_vec_i,
    input  logic                     snp_vld_i,
    input  logic [$clog2(NCORE)-1:0] snp_core_i,
    output logic                     local_spec_o,
    output logic                     wr_earlier_o,
    output logic                     wr_later_o
);
    localparam int CORE_W = $clog2(NCORE);

    logic [SEQ_W-1:0] seq_arr [NCORE];
    logic [SEQ_W-1:0] local_seq;
    logic [SEQ_W-1:0] writer_seq;
    logic             foreign;

    for (genvar c = 0; c < NCORE; c++) begin : g_seq
        assign seq_arr[c] = seq_vec_i[c*SEQ_W +: SEQ_W];
    end

    assign local_seq    = seq_arr[LOCAL_ID];
    assign writer_seq   = seq_arr[snp_core_i];
    assign foreign      = (snp_core_i != CORE_W'(LOCAL_ID));
    assign local_spec_o = (local_seq != '0);
    assign wr_earlier_o = snp_vld_i && foreign && (writer_seq < local_seq);
    assign wr_later_o   = snp_vld_i && foreign && (writer_seq > local_seq);

endmodule

// File: rtl/spec_way_match.sv
module spec_way_match #(
    parameter int WAYS  = 4,
    parameter int TAG_W = 8
) (
    input  logic [WAYS-1:0]       vld_i,
    input  logic [WAYS*TAG_W-1:0] tag_i,
    input  logic                  req_vld_i,
    input  logic [TAG_W-1:0]      req_tag_i,
    output logic [WAYS-1:0]       hit_o
);
    for (genvar w = 0; w < WAYS; w++) begin : g_way
        assign hit_o[w] = req_vld_i && vld_i[w] &&
                          (tag_i[w*TAG_W +: TAG_W] == req_tag_i);
    end

endmodule

// File: rtl/spec_line_array.sv
module spec_line_array
    import spec_trk_pkg::*;
#(
    parameter int SETS  = 16,
    parameter int WAYS  = 4,
    parameter int TAG_W = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    commit_i,
    input  logic                    squash_i,
    input  logic                    fill_en_i,
    input  logic [$clog2(SETS)-1:0] fill_set_i,
    input  logic [$clog2(WAYS)-1:0] fill_way_i,
    input  logic [TAG_W-1:0]        fill_tag_i,
    input  logic [$clog2(SETS)-1:0] acc_set_i,
    input  logic [WAYS-1:0]         acc_hitv_i,
    input  logic                    mark_rd_i,
    input  logic                    mark_md_i,
    input  logic [$clog2(SETS)-1:0] snp_set_i,
    input  logic [WAYS-1:0]         snp_hitv_i,
    input  logic                    snp_inv_i,
    input  logic                    snp_pre_i,
    output logic [WAYS-1:0]         acc_vld_row_o,
    output logic [WAYS*TAG_W-1:0]   acc_tag_row_o,
    output logic [WAYS-1:0]         snp_vld_row_o,
    output logic [WAYS*TAG_W-1:0]   snp_tag_row_o,
    output logic [WAYS-1:0]         snp_rd_row_o
);
    localparam int SET_W = $clog2(SETS);
    localparam int WAY_W = $clog2(WAYS);
    localparam int LINES = SETS * WAYS;

    logic [LINES-1:0] vld_w;
    logic [LINES-1:0] rd_w;
    logic [TAG_W-1:0] tag_w [LINES];

    for (genvar s = 0; s < SETS; s++) begin : g_set
        for (genvar w = 0; w < WAYS; w++) begin : g_line
            logic             v_q;
            logic [TAG_W-1:0] t_q;
            spec_bits_t       b_q;
            logic             fill_here;
            logic             acc_here;
            logic             snp_here;

            assign fill_here = fill_en_i && (fill_set_i == SET_W'(s)) &&
                               (fill_way_i == WAY_W'(w));
            assign acc_here  = acc_hitv_i[w] && (acc_set_i == SET_W'(s));
            assign snp_here  = snp_hitv_i[w] && (snp_set_i == SET_W'(s));

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    v_q <= 1'b0;
                    t_q <= '0;
                    b_q <= '0;
                end else if (squash_i) begin
                    if (b_q.md) v_q <= 1'b0;
                    b_q <= '0;
                end else if (commit_i) begin
                    if (b_q.pi) v_q <= 1'b0;
                    b_q <= '0;
                end else begin
                    if (fill_here) begin
                        v_q <= 1'b1;
                        t_q <= fill_tag_i;
                        b_q <= '0;
                    end else begin
                        if (acc_here && mark_rd_i) b_q.rd <= 1'b1;
                        if (acc_here && mark_md_i) b_q.md <= 1'b1;
                    end
                    if (snp_here && snp_inv_i) begin
                        v_q <= 1'b0;
                        b_q <= '0;
                    end else if (snp_here && snp_pre_i) begin
                        b_q.pi <= 1'b1;
                    end
                end
            end

            assign vld_w[s*WAYS+w] = v_q;
            assign rd_w[s*WAYS+w]  = b_q.rd;
            assign tag_w[s*WAYS+w] = t_q;
        end
    end

    for (genvar w = 0; w < WAYS; w++) begin : g_row
        assign acc_vld_row_o[w]               = vld_w[{acc_set_i, WAY_W'(w)}];
        assign acc_tag_row_o[w*TAG_W +: TAG_W] = tag_w[{acc_set_i, WAY_W'(w)}];
        assign snp_vld_row_o[w]               = vld_w[{snp_set_i, WAY_W'(w)}];
        assign snp_tag_row_o[w*TAG_W +: TAG_W] = tag_w[{snp_set_i, WAY_W'(w)}];
        assign snp_rd_row_o[w]                = rd_w[{snp_set_i, WAY_W'(w)}];
    end

endmodule

// File: rtl/spec_line_tracker.sv
module spec_line_tracker
    import spec_trk_pkg::*;
#(
    parameter int SETS     = 16,
    parameter int WAYS     = 4,
    parameter int TAG_W    = 8,
    parameter int NCORE    = 4,
    parameter int SEQ_W    = 2,
    parameter int LOCAL_ID = 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NCORE*SEQ_W-1:0]   seq_vec_i,
    input  logic                     fill_vld_i,
    input  logic [$clog2(SETS)-1:0]  fill_set_i,
    input  logic [$clog2(WAYS)-1:0]  fill_way_i,
    input  logic [TAG_W-1:0]         fill_tag_i,
    input  logic                     acc_vld_i,
    input  logic                     acc_wr_i,
    input  logic [$clog2(SETS)-1:0]  acc_set_i,
    input  logic [TAG_W-1:0]         acc_tag_i,
    input  logic                     snp_vld_i,
    input  logic [$clog2(NCORE)-1:0] snp_core_i,
    input  logic [$clog2(SETS)-1:0]  snp_set_i,
    input  logic [TAG_W-1:0]         snp_tag_i,
    input  logic                     commit_i,
    input  logic                     squash_i,
    output logic                     acc_hit_o,
    output logic                     viol_o
);
    trk_state_e          state_q;
    trk_state_e          state_d;
    logic                flash;
    logic                local_spec;
    logic                wr_earlier;
    logic                wr_later;
    logic [WAYS-1:0]     acc_vld_row;
    logic [WAYS*TAG_W-1:0] acc_tag_row;
    logic [WAYS-1:0]     snp_vld_row;
    logic [WAYS*TAG_W-1:0] snp_tag_row;
    logic [WAYS-1:0]     snp_rd_row;
    logic [WAYS-1:0]     acc_hitv;
    logic [WAYS-1:0]     snp_hitv;
    logic                acc_hit;
    logic                viol_hit;
    logic                mark_rd;
    logic                mark_md;
    logic                hit_q;
    logic                viol_q;

    assign flash = commit_i | squash_i;

    spec_order_cmp #(
        .NCORE    (NCORE),
        .SEQ_W    (SEQ_W),
        .LOCAL_ID (LOCAL_ID)
    ) i_order (
        .seq_vec_i    (seq_vec_i),
        .snp_vld_i    (snp_vld_i),
        .snp_core_i   (snp_core_i),
        .local_spec_o (local_spec),
        .wr_earlier_o (wr_earlier),
        .wr_later_o   (wr_later)
    );

    spec_way_match #(.WAYS(WAYS), .TAG_W(TAG_W)) i_acc_match (
        .vld_i     (acc_vld_row),
        .tag_i     (acc_tag_row),
        .req_vld_i (acc_vld_i),
        .req_tag_i (acc_tag_i),
        .hit_o     (acc_hitv)
    );

    spec_way_match #(.WAYS(WAYS), .TAG_W(TAG_W)) i_snp_match (
        .vld_i     (snp_vld_row),
        .tag_i     (snp_tag_row),
        .req_vld_i (snp_vld_i),
        .req_tag_i (snp_tag_i),
        .hit_o     (snp_hitv)
    );

    assign acc_hit  = |acc_hitv;
    assign mark_rd  = acc_vld_i && !acc_wr_i && local_spec;
    assign mark_md  = acc_vld_i && acc_wr_i && local_spec;
    assign viol_hit = wr_earlier && |(snp_hitv & snp_rd_row);

    spec_line_array #(
        .SETS  (SETS),
        .WAYS  (WAYS),
        .TAG_W (TAG_W)
    ) i_lines (
        .clk           (clk),
        .rst_n         (rst_n),
        .commit_i      (commit_i),
        .squash_i      (squash_i),
        .fill_en_i     (fill_vld_i),
        .fill_set_i    (fill_set_i),
        .fill_way_i    (fill_way_i),
        .fill_tag_i    (fill_tag_i),
        .acc_set_i     (acc_set_i),
        .acc_hitv_i    (acc_hitv),
        .mark_rd_i     (mark_rd),
        .mark_md_i     (mark_md),
        .snp_set_i     (snp_set_i),
        .snp_hitv_i    (snp_hitv),
        .snp_inv_i     (wr_earlier),
        .snp_pre_i     (wr_later),
        .acc_vld_row_o (acc_vld_row),
        .acc_tag_row_o (acc_tag_row),
        .snp_vld_row_o (snp_vld_row),
        .snp_tag_row_o (snp_tag_row),
        .snp_rd_row_o  (snp_rd_row)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= TRK_ARMED;
        else        state_q <= state_d;
    end

    // transitions: violate (ARMED->TRIPPED), rearm (TRIPPED->ARMED)
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TRK_ARMED:   if (!flash && viol_hit) state_d = TRK_TRIPPED;
            TRK_TRIPPED: if (flash)              state_d = TRK_ARMED;
        endcase
    end

    // registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hit_q  <= 1'b0;
            viol_q <= 1'b0;
        end else begin
            hit_q  <= acc_hit && !flash;
            viol_q <= (state_q == TRK_ARMED) && viol_hit && !flash;
        end
    end

    assign acc_hit_o = hit_q;
    assign viol_o    = viol_q;

endmodule

// File: rtl/spec_line_tracker_chk.sv
module spec_line_tracker_chk #(
    parameter int NCORE    = 4,
    parameter int SEQ_W    = 2,
    parameter int LOCAL_ID = 1
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic [NCORE*SEQ_W-1:0]   seq_vec_i,
    input logic                     acc_vld_i,
    input logic                     snp_vld_i,
    input logic [$clog2(NCORE)-1:0] snp_core_i,
    input logic                     commit_i,
    input logic                     squash_i,
    input logic                     acc_hit_o,
    input logic                     viol_o
);
    logic [SEQ_W-1:0] my_seq;
    logic [SEQ_W-1:0] wr_seq;
    logic             earlier_c;

    assign my_seq    = seq_vec_i[LOCAL_ID*SEQ_W +: SEQ_W];
    assign wr_seq    = seq_vec_i[snp_core_i*SEQ_W +: SEQ_W];
    assign earlier_c = snp_vld_i && (int'(snp_core_i) != LOCAL_ID) && (wr_seq < my_seq);

    AST_HIT_NEEDS_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
        acc_hit_o |-> $past(acc_vld_i)); // R2
    AST_VIOL_FROM_EARLIER: assert property (@(posedge clk) disable iff (!rst_n)
        viol_o |-> $past(earlier_c)); // R3
    AST_HEAD_NEVER_VIOL: assert property (@(posedge clk) disable iff (!rst_n)
        viol_o |-> $past(my_seq) != '0); // R7
    AST_SELF_SNOOP_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        viol_o |-> int'($past(snp_core_i)) != LOCAL_ID); // R8
    AST_VIOL_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        viol_o |=> !viol_o); // R9
    AST_FLASH_DROPS_INPUTS: assert property (@(posedge clk) disable iff (!rst_n)
        $past(commit_i || squash_i) |-> (!acc_hit_o && !viol_o)); // R11

endmodule

bind spec_line_tracker spec_line_tracker_chk #(
    .NCORE    (NCORE),
    .SEQ_W    (SEQ_W),
    .LOCAL_ID (LOCAL_ID)
) i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .seq_vec_i  (seq_vec_i),
    .acc_vld_i  (acc_vld_i),
    .snp_vld_i  (snp_vld_i),
    .snp_core_i (snp_core_i),
    .commit_i   (commit_i),
    .squash_i   (squash_i),
    .acc_hit_o  (acc_hit_o),
    .viol_o     (viol_o)
);

// File: tb/test_spec_line_tracker.sv
module test_spec_line_tracker;
    localparam int CLK_PERIOD = 10;
    localparam int K_IDLE = 0, K_FILL = 1, K_LD = 2, K_ST = 3, K_SNP = 4;
    localparam int F_NONE = 0, F_COMMIT = 1, F_SQUASH = 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] seq_vec = '0;
    logic       fill_vld = 0, acc_vld = 0, acc_wr = 0, snp_vld = 0;
    logic [3:0] fill_set = '0, acc_set = '0, snp_set = '0;
    logic [1:0] fill_way = '0, snp_core = '0;
    logic [7:0] fill_tag = '0, acc_tag = '0, snp_tag = '0;
    logic       commit = 0, squash = 0;
    logic       acc_hit, viol;

    int n_checks = 0;
    int n_fail = 0;

    typedef struct {
        logic  hit;
        logic  viol;
        string req;
    } exp_t;
    exp_t exp_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    spec_line_tracker i_spec_line_tracker (
        .clk        (clk),
        .rst_n      (rst_n),
        .seq_vec_i  (seq_vec),
        .fill_vld_i (fill_vld),
        .fill_set_i (fill_set),
        .fill_way_i (fill_way),
        .fill_tag_i (fill_tag),
        .acc_vld_i  (acc_vld),
        .acc_wr_i   (acc_wr),
        .acc_set_i  (acc_set),
        .acc_tag_i  (acc_tag),
        .snp_vld_i  (snp_vld),
        .snp_core_i (snp_core),
        .snp_set_i  (snp_set),
        .snp_tag_i  (snp_tag),
        .commit_i   (commit),
        .squash_i   (squash),
        .acc_hit_o  (acc_hit),
        .viol_o     (viol)
    );

    task automatic clear_inputs();
        fill_vld = 0; acc_vld = 0; acc_wr = 0; snp_vld = 0;
        commit = 0; squash = 0;
    endtask

    task automatic set_seq(input int c0, input int c1, input int c2, input int c3);
        seq_vec = {2'(c3), 2'(c2), 2'(c1), 2'(c0)};
    endtask

    // driver: one operation per cycle, expected outputs pushed to the scoreboard
    task automatic op(input int kind, input int flash, input int s, input int t,
                      input int aux, input logic eh, input logic ev, input string req);
        exp_t e;
        @(negedge clk);
        clear_inputs();
        case (kind)
            K_FILL: begin fill_vld = 1; fill_set = 4'(s); fill_tag = 8'(t); fill_way = 2'(aux); end
            K_LD:   begin acc_vld = 1; acc_wr = 0; acc_set = 4'(s); acc_tag = 8'(t); end
            K_ST:   begin acc_vld = 1; acc_wr = 1; acc_set = 4'(s); acc_tag = 8'(t); end
            K_SNP:  begin snp_vld = 1; snp_set = 4'(s); snp_tag = 8'(t); snp_core = 2'(aux); end
            default: ;
        endcase
        commit = (flash == F_COMMIT);
        squash = (flash == F_SQUASH);
        e.hit = eh; e.viol = ev; e.req = req;
        exp_q.push_back(e);
        @(posedge clk);
        #1 clear_inputs();
    endtask

    // monitor: compares registered outputs after the edge that captured each operation
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (exp_q.size() > 0) begin
                exp_t e;
                e = exp_q.pop_front();
                n_checks++;
                if (acc_hit !== e.hit || viol !== e.viol) begin
                    n_fail++;
                    $display("FAIL %s: hit=%b viol=%b expected hit=%b viol=%b",
                             e.req, acc_hit, viol, e.hit, e.viol);
                end
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 20000);
        n_fail++;
        $display("FAIL watchdog: run did not finish, actual=hung expected=done");
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        clear_inputs();
        repeat (3) @(posedge clk);
        #2;
        n_checks++;
        if (acc_hit !== 1'b0 || viol !== 1'b0) begin
            n_fail++;
            $display("FAIL R1: hit=%b viol=%b expected hit=0 viol=0", acc_hit, viol);
        end
        @(negedge clk);
        rst_n = 1;
        set_seq(0, 1, 2, 3);
        op(K_LD, F_NONE, 3, 0, 0, 0, 0, "R1 empty array misses tag 0");

        op(K_FILL, F_NONE, 3, 'h11, 0, 0, 0, "R2 fill");
        op(K_FILL, F_NONE, 3, 'h22, 2, 0, 0, "R2 fill");
        op(K_FILL, F_NONE, 5, 'h33, 1, 0, 0, "R2 fill");
        op(K_LD,   F_NONE, 3, 'h11, 0, 1, 0, "R2 hit way0");
        op(K_LD,   F_NONE, 3, 'h22, 0, 1, 0, "R2 hit way2");
        op(K_LD,   F_NONE, 3, 'h44, 0, 0, 0, "R2 miss other tag");

        op(K_SNP, F_NONE, 3, 'h11, 3, 0, 0, "R5 later write no violation");
        op(K_LD,  F_NONE, 3, 'h11, 0, 1, 0, "R5 later write keeps line");
        op(K_SNP, F_NONE, 3, 'h11, 0, 0, 1, "R3 earlier write on read line");
        op(K_LD,  F_NONE, 3, 'h11, 0, 0, 0, "R4 earlier write invalidates");

        op(K_FILL, F_NONE, 3, 'h11, 0, 0, 0, "R9 refill");
        op(K_LD,   F_NONE, 3, 'h11, 0, 1, 0, "R9 reload");
        op(K_SNP,  F_NONE, 3, 'h11, 0, 0, 0, "R9 second violation suppressed");
        op(K_IDLE, F_SQUASH, 0, 0, 0, 0, 0, "R9 squash");
        op(K_FILL, F_NONE, 3, 'h11, 0, 0, 0, "R9 refill");
        op(K_LD,   F_NONE, 3, 'h11, 0, 1, 0, "R9 reload");
        op(K_SNP,  F_NONE, 3, 'h11, 0, 0, 1, "R9 rearmed after squash");

        op(K_SNP, F_NONE, 5, 'h33, 0, 0, 0, "R4 unread line no violation");
        op(K_LD,  F_NONE, 5, 'h33, 0, 0, 0, "R4 unread line invalidated");
        op(K_IDLE, F_COMMIT, 0, 0, 0, 0, 0, "R10 commit");

        op(K_FILL, F_NONE, 5, 'h33, 1, 0, 0, "R5 fill");
        op(K_FILL, F_NONE, 7, 'h55, 3, 0, 0, "R5 fill");
        op(K_SNP,  F_NONE, 5, 'h33, 2, 0, 0, "R5 later write");
        op(K_LD,   F_NONE, 5, 'h33, 0, 1, 0, "R5 still valid before commit");
        op(K_IDLE, F_COMMIT, 0, 0, 0, 0, 0, "R5 commit");
        op(K_LD,   F_NONE, 5, 'h33, 0, 0, 0, "R5 pre-invalidated line gone");
        op(K_LD,   F_NONE, 7, 'h55, 0, 1, 0, "R5 other line kept");
        op(K_IDLE, F_COMMIT, 0, 0, 0, 0, 0, "R10 commit");
        op(K_SNP,  F_NONE, 7, 'h55, 0, 0, 0, "R10 read mark cleared by commit");
        op(K_LD,   F_NONE, 7, 'h55, 0, 0, 0, "R4 invalidated");

        op(K_FILL, F_NONE, 2, 'h66, 0, 0, 0, "R6 fill");
        op(K_FILL, F_NONE, 2, 'h77, 1, 0, 0, "R6 fill");
        op(K_ST,   F_NONE, 2, 'h66, 0, 1, 0, "R6 speculative store hit");
        op(K_IDLE, F_SQUASH, 0, 0, 0, 0, 0, "R6 squash");
        op(K_LD,   F_NONE, 2, 'h66, 0, 0, 0, "R6 modified line dropped");
        op(K_LD,   F_NONE, 2, 'h77, 0, 1, 0, "R6 clean line kept");

        set_seq(1, 0, 2, 3);
        op(K_FILL, F_NONE, 4, 'h88, 0, 0, 0, "R7 fill");
        op(K_ST,   F_NONE, 4, 'h88, 0, 1, 0, "R7 head store");
        op(K_LD,   F_NONE, 4, 'h88, 0, 1, 0, "R7 head load");
        op(K_IDLE, F_SQUASH, 0, 0, 0, 0, 0, "R7 squash");
        op(K_LD,   F_NONE, 4, 'h88, 0, 1, 0, "R7 head store left no mark");
        set_seq(1, 2, 0, 3);
        op(K_SNP,  F_NONE, 4, 'h88, 0, 0, 0, "R7 head load left no read mark");
        op(K_LD,   F_NONE, 4, 'h88, 0, 0, 0, "R4 invalidated");

        op(K_FILL, F_NONE, 6, 'h99, 2, 0, 0, "R8 fill");
        op(K_LD,   F_NONE, 6, 'h99, 0, 1, 0, "R8 load sets read");
        op(K_SNP,  F_NONE, 6, 'h99, 1, 0, 0, "R8 own write ignored");
        op(K_LD,   F_NONE, 6, 'h99, 0, 1, 0, "R8 line kept");

        op(K_LD,   F_COMMIT, 6, 'h99, 0, 0, 0, "R11 access dropped during commit");
        op(K_LD,   F_NONE, 6, 'h99, 0, 1, 0, "R11 line survives commit");
        op(K_SNP,  F_SQUASH, 6, 'h99, 0, 0, 0, "R11 snoop dropped during squash");
        op(K_LD,   F_NONE, 6, 'h99, 0, 1, 0, "R11 snoop had no effect");
        op(K_FILL, F_COMMIT, 8, 'hAA, 0, 0, 0, "R11 fill dropped during commit");
        op(K_LD,   F_NONE, 8, 'hAA, 0, 0, 0, "R11 dropped fill not installed");

        repeat (3) @(posedge clk);
        #3;
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule